// File: doc/BRIEF.md
# Video Input Stream Router

This block sits behind the decoder of a BT.656-style video input port and takes its already-decoded byte stream, one byte per input clock when `inValid` is high. Each byte carries a class flag: active video or raw VBI. Each class is steered to one of three buffers, and each buffer hands its bytes to a consumer running on its own clock. The shared capture buffer is drained by a bus-master clock and holds both classes, each entry tagged with its class. The direct video buffer feeds a video output port clock. The direct VBI buffer feeds a TV pixel clock.

The direct paths have no enable of their own. A byte goes direct unless its stream's select field points it at the capture buffer; for video, a select value can also discard the byte. Video and VBI choose their paths independently. A new select value is adopted only on the decoder's frame-start strobe, so a field never straddles two paths. A byte that meets a full buffer is dropped, and a sticky per-path overflow flag records the loss. Software clears that flag by writing 1 to it.

Top module: `vstream_router`

## Requirements
- R1: After reset all three buffers report empty, `ovfFlag` is 3'b000, and both streams select their direct path until the first frame-start strobe.
- R2: Video select `cfgSel[1:0]` works as follows. 2'b00 sends video bytes to the direct video buffer. 2'b01 sends them to the capture buffer with `capIsVbi`=0. 2'b10 and 2'b11 discard them without setting any overflow flag.
- R3: VBI select `cfgSel[2]` works as follows. 0 sends VBI bytes to the direct VBI buffer. 1 sends them to the capture buffer with `capIsVbi`=1.
- R4: The path taken by a byte depends only on its own stream's select field, so every combination of the two fields is legal.
- R5: `cfgSel` is sampled only in a cycle where `frameStart` is high, and a byte presented in that same cycle already follows the new value. Changes to `cfgSel` without the strobe have no effect on routing.
- R6: Each buffer delivers its bytes in arrival order. Data and tag are valid whenever the buffer is not empty, and a read strobe advances the buffer by one entry.
- R7: Capacity is 128 entries for the capture buffer, 2048 for direct video and 128 for direct VBI.
- R8: A byte routed to a full buffer is dropped, and the stored contents are unchanged. The byte sets the overflow flag for its path: bit 0 for capture, bit 1 for direct video, bit 2 for direct VBI.
- R9: Writing 1 to an `ovfClear` bit clears that flag. If a drop on the same path happens in the same cycle, the flag stays set.
- R10: A read strobe while a buffer is empty leaves that buffer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| inClk | input | 1 | Video input clock (write side of all buffers) |
| rstN | input | 1 | Asynchronous active-low reset for all domains |
| inValid | input | 1 | Byte present on `inData` this cycle |
| inData | input | 8 | Decoded byte |
| inIsVbi | input | 1 | 1 = raw VBI byte, 0 = active video byte |
| frameStart | input | 1 | Frame-start strobe; adopts `cfgSel` |
| cfgSel | input | 3 | [1:0] video select, [2] VBI select |
| ovfClear | input | 3 | Write-1-to-clear for `ovfFlag` (inClk domain) |
| ovfFlag | output | 3 | Sticky overflow flags: [0] capture, [1] direct video, [2] direct VBI |
| capClk | input | 1 | Capture buffer read clock |
| capRd | input | 1 | Capture read strobe |
| capData | output | 8 | Capture head byte |
| capIsVbi | output | 1 | Class tag of capture head byte |
| capEmpty | output | 1 | Capture buffer empty |
| dvClk | input | 1 | Direct video read clock |
| dvRd | input | 1 | Direct video read strobe |
| dvData | output | 8 | Direct video head byte |
| dvEmpty | output | 1 | Direct video buffer empty |
| tvClk | input | 1 | Direct VBI read clock |
| tvRd | input | 1 | Direct VBI read strobe |
| tvData | output | 8 | Direct VBI head byte |
| tvEmpty | output | 1 | Direct VBI buffer empty |

## Verification
Two pairs of events can land in the same input cycle. The first pair is a frame-start strobe and the byte whose routing it changes. The bench raises `frameStart` together with the first byte of every sweep phase and requires that byte to appear on the newly selected path. The second pair is an overflow clear and a fresh drop on the same path. The bench holds the capture buffer full, then presents one more byte with the matching `ovfClear` bit high and expects the flag to remain set. A later clear on its own must bring the flag to zero.

// File: rtl/vsr_pkg.sv
package vsr_pkg;
  localparam int VID_SEL_W = 2;
  localparam int CFG_W     = VID_SEL_W + 1;
  localparam int NUM_PATHS = 3;
  localparam int PATH_CAP  = 0;
  localparam int PATH_DV   = 1;
  localparam int PATH_TV   = 2;

  typedef enum logic [VID_SEL_W-1:0] {
    VID_DIRECT  = 2'b00,
    VID_CAPTURE = 2'b01,
    VID_DROP_LO = 2'b10,
    VID_DROP_HI = 2'b11
  } vid_sel_e;

  // Write strobes from control to datapath, already gated by fullness
  typedef struct packed {
    logic capWr;
    logic capTag;
    logic dvWr;
    logic tvWr;
  } wr_stb_t;
endpackage

// File: rtl/vsr_afifo.sv
module vsr_afifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 128
) (
  input  logic             wrClk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  output logic             full,
  input  logic             rdClk,
  input  logic             rdEn,
  output logic [WIDTH-1:0] rdData,
  output logic             empty
);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW:0] wrBin, wrGray, wrBinNext;
  logic [AW:0] rdBin, rdGray, rdBinNext;
  logic [AW:0] rdGrayW1, rdGrayW2, wrGrayR1, wrGrayR2;
  logic        wrDo, rdDo;

  assign wrDo      = wrEn && !full;
  assign rdDo      = rdEn && !empty;
  assign wrBinNext = wrBin + (AW+1)'(wrDo);
  assign rdBinNext = rdBin + (AW+1)'(rdDo);

  // write domain
  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrBin    <= '0;
      wrGray   <= '0;
      rdGrayW1 <= '0;
      rdGrayW2 <= '0;
    end else begin
      wrBin    <= wrBinNext;
      wrGray   <= wrBinNext ^ (wrBinNext >> 1);
      rdGrayW1 <= rdGray;
      rdGrayW2 <= rdGrayW1;
    end
  end

  always_ff @(posedge wrClk) begin
    if (wrDo) mem[wrBin[AW-1:0]] <= wrData;
  end

  assign full = (wrGray == {~rdGrayW2[AW:AW-1], rdGrayW2[AW-2:0]});

  // read domain
  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdBin    <= '0;
      rdGray   <= '0;
      wrGrayR1 <= '0;
      wrGrayR2 <= '0;
    end else begin
      rdBin    <= rdBinNext;
      rdGray   <= rdBinNext ^ (rdBinNext >> 1);
      wrGrayR1 <= wrGray;
      wrGrayR2 <= wrGrayR1;
    end
  end

  assign empty  = (rdGray == wrGrayR2);
  assign rdData = mem[rdBin[AW-1:0]];
endmodule

// File: rtl/vsr_datapath.sv
module vsr_datapath
  import vsr_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int CAP_DEPTH = 128,
  parameter int DV_DEPTH  = 2048,
  parameter int TV_DEPTH  = 128
) (
  input  logic                 inClk,
  input  logic                 rstN,
  input  logic [DATA_W-1:0]    inData,
  input  wr_stb_t              stb,
  output logic [NUM_PATHS-1:0] fullVec,
  input  logic                 capClk,
  input  logic                 capRd,
  output logic [DATA_W-1:0]    capData,
  output logic                 capIsVbi,
  output logic                 capEmpty,
  input  logic                 dvClk,
  input  logic                 dvRd,
  output logic [DATA_W-1:0]    dvData,
  output logic                 dvEmpty,
  input  logic                 tvClk,
  input  logic                 tvRd,
  output logic [DATA_W-1:0]    tvData,
  output logic                 tvEmpty
);
  localparam int CAP_W = DATA_W + 1;

  logic [CAP_W-1:0] capWord;

  vsr_afifo #(.WIDTH(CAP_W), .DEPTH(CAP_DEPTH)) capFifo (
    .wrClk(inClk), .rstN(rstN), .wrEn(stb.capWr), .wrData({stb.capTag, inData}),
    .full(fullVec[PATH_CAP]),
    .rdClk(capClk), .rdEn(capRd), .rdData(capWord), .empty(capEmpty)
  );
  assign capIsVbi = capWord[CAP_W-1];
  assign capData  = capWord[DATA_W-1:0];

  vsr_afifo #(.WIDTH(DATA_W), .DEPTH(DV_DEPTH)) dvFifo (
    .wrClk(inClk), .rstN(rstN), .wrEn(stb.dvWr), .wrData(inData),
    .full(fullVec[PATH_DV]),
    .rdClk(dvClk), .rdEn(dvRd), .rdData(dvData), .empty(dvEmpty)
  );

  vsr_afifo #(.WIDTH(DATA_W), .DEPTH(TV_DEPTH)) tvFifo (
    .wrClk(inClk), .rstN(rstN), .wrEn(stb.tvWr), .wrData(inData),
    .full(fullVec[PATH_TV]),
    .rdClk(tvClk), .rdEn(tvRd), .rdData(tvData), .empty(tvEmpty)
  );
endmodule

// File: rtl/vsr_ctrl.sv
module vsr_ctrl
  import vsr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic                 inIsVbi,
  input  logic                 frameStart,
  input  logic [CFG_W-1:0]     cfgSel,
  input  logic [NUM_PATHS-1:0] ovfClear,
  input  logic [NUM_PATHS-1:0] fullVec,
  output wr_stb_t              stb,
  output logic [NUM_PATHS-1:0] ovfFlag
);
  vid_sel_e vidSel, vidSelEff;
  logic     vbiSel, vbiSelEff;
  logic [NUM_PATHS-1:0] want, accept, drop;

  // selects are adopted only on the frame-start strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vidSel <= VID_DIRECT;
      vbiSel <= 1'b0;
    end else if (frameStart) begin
      vidSel <= vid_sel_e'(cfgSel[VID_SEL_W-1:0]);
      vbiSel <= cfgSel[VID_SEL_W];
    end
  end

  // the strobe byte itself already follows the new select
  always_comb begin
    vidSelEff = frameStart ? vid_sel_e'(cfgSel[VID_SEL_W-1:0]) : vidSel;
    vbiSelEff = frameStart ? cfgSel[VID_SEL_W] : vbiSel;
  end

  always_comb begin
    want = '0;
    if (inValid) begin
      if (inIsVbi) begin
        if (vbiSelEff) want[PATH_CAP] = 1'b1;
        else           want[PATH_TV]  = 1'b1;
      end else begin
        case (vidSelEff)
          VID_DIRECT:  want[PATH_DV]  = 1'b1;
          VID_CAPTURE: want[PATH_CAP] = 1'b1;
          default:     want = '0;
        endcase
      end
    end
  end

  assign accept = want & ~fullVec;
  assign drop   = want & fullVec;

  always_comb begin
    stb.capWr  = accept[PATH_CAP];
    stb.capTag = inIsVbi;
    stb.dvWr   = accept[PATH_DV];
    stb.tvWr   = accept[PATH_TV];
  end

  // sticky overflow; a drop in the clearing cycle wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ovfFlag <= '0;
    else       ovfFlag <= (ovfFlag & ~ovfClear) | drop;
  end
endmodule

// File: rtl/vstream_router.sv
module vstream_router
  import vsr_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int CAP_DEPTH = 128,
  parameter int DV_DEPTH  = 2048,
  parameter int TV_DEPTH  = 128
) (
  input  logic                 inClk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic [DATA_W-1:0]    inData,
  input  logic                 inIsVbi,
  input  logic                 frameStart,
  input  logic [CFG_W-1:0]     cfgSel,
  input  logic [NUM_PATHS-1:0] ovfClear,
  output logic [NUM_PATHS-1:0] ovfFlag,
  input  logic                 capClk,
  input  logic                 capRd,
  output logic [DATA_W-1:0]    capData,
  output logic                 capIsVbi,
  output logic                 capEmpty,
  input  logic                 dvClk,
  input  logic                 dvRd,
  output logic [DATA_W-1:0]    dvData,
  output logic                 dvEmpty,
  input  logic                 tvClk,
  input  logic                 tvRd,
  output logic [DATA_W-1:0]    tvData,
  output logic                 tvEmpty
);
  wr_stb_t              wrStb;
  logic [NUM_PATHS-1:0] fullVec;

  vsr_ctrl ctrl (
    .clk(inClk), .rstN(rstN), .inValid(inValid), .inIsVbi(inIsVbi),
    .frameStart(frameStart), .cfgSel(cfgSel), .ovfClear(ovfClear),
    .fullVec(fullVec), .stb(wrStb), .ovfFlag(ovfFlag)
  );

  vsr_datapath #(
    .DATA_W(DATA_W), .CAP_DEPTH(CAP_DEPTH), .DV_DEPTH(DV_DEPTH), .TV_DEPTH(TV_DEPTH)
  ) dp (
    .inClk(inClk), .rstN(rstN), .inData(inData), .stb(wrStb), .fullVec(fullVec),
    .capClk(capClk), .capRd(capRd), .capData(capData), .capIsVbi(capIsVbi), .capEmpty(capEmpty),
    .dvClk(dvClk), .dvRd(dvRd), .dvData(dvData), .dvEmpty(dvEmpty),
    .tvClk(tvClk), .tvRd(tvRd), .tvData(tvData), .tvEmpty(tvEmpty)
  );
endmodule

// File: rtl/vsr_checker.sv
module vsr_checker
  import vsr_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 inValid,
  input logic                 inIsVbi,
  input wr_stb_t              stb,
  input logic [NUM_PATHS-1:0] fullVec,
  input logic [NUM_PATHS-1:0] ovfFlag,
  input logic [NUM_PATHS-1:0] ovfClear
);
  // R4
  one_path_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.capWr, stb.dvWr, stb.tvWr}));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |-> !(stb.capWr || stb.dvWr || stb.tvWr));

  // R3
  vbi_class_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inIsVbi) |-> !stb.dvWr);

  // R2
  vid_class_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !inIsVbi) |-> !stb.tvWr);

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (({stb.capWr, stb.dvWr, stb.tvWr} &
      {fullVec[PATH_CAP], fullVec[PATH_DV], fullVec[PATH_TV]}) == 3'b000));

  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_sticky
    // R9
    sticky_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
      (ovfFlag[p] && !ovfClear[p]) |=> ovfFlag[p]);
  end
endmodule

bind vstream_router vsr_checker chk (
  .clk(inClk), .rstN(rstN), .inValid(inValid), .inIsVbi(inIsVbi),
  .stb(wrStb), .fullVec(fullVec), .ovfFlag(ovfFlag), .ovfClear(ovfClear)
);

// File: tb/tb_vstream_router.sv
module tb_vstream_router;
  localparam int CAP_D = 128;
  localparam int DV_D  = 2048;
  localparam int TV_D  = 128;

  logic       inClk = 0, capClk = 0, dvClk = 0, tvClk = 0;
  logic       rstN = 0;
  logic       inValid = 0, inIsVbi = 0, frameStart = 0;
  logic [7:0] inData = 0;
  logic [2:0] cfgSel = 0, ovfClear = 0;
  logic [2:0] ovfFlag;
  logic       capRd = 0, dvRd = 0, tvRd = 0;
  logic [7:0] capData, dvData, tvData;
  logic       capIsVbi, capEmpty, dvEmpty, tvEmpty;

  always #10 inClk  = ~inClk;   // 50 MHz
  always #15 capClk = ~capClk;
  always #7  dvClk  = ~dvClk;
  always #19 tvClk  = ~tvClk;

  vstream_router dut (
    .inClk(inClk), .rstN(rstN), .inValid(inValid), .inData(inData), .inIsVbi(inIsVbi),
    .frameStart(frameStart), .cfgSel(cfgSel), .ovfClear(ovfClear), .ovfFlag(ovfFlag),
    .capClk(capClk), .capRd(capRd), .capData(capData), .capIsVbi(capIsVbi), .capEmpty(capEmpty),
    .dvClk(dvClk), .dvRd(dvRd), .dvData(dvData), .dvEmpty(dvEmpty),
    .tvClk(tvClk), .tvRd(tvRd), .tvData(tvData), .tvEmpty(tvEmpty)
  );

  int nChk = 0, nBad = 0;
  logic [8:0] capQ[$];
  logic [7:0] dvQ[$], tvQ[$];
  logic [1:0] curV = 2'b00;
  logic       curB = 1'b0;
  logic [2:0] expOvf = 3'b000;

  task automatic chk(string req, int act, int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
  endtask

  // one byte in one input cycle; model updated from the requirements
  task automatic sendByte(logic [7:0] d, logic vbi, logic fs, logic [2:0] clr);
    logic [2:0] hit;
    logic [1:0] effV;
    logic       effB;
    @(negedge inClk);
    inValid = 1; inData = d; inIsVbi = vbi; frameStart = fs; ovfClear = clr;
    effV = fs ? cfgSel[1:0] : curV;
    effB = fs ? cfgSel[2]   : curB;
    if (fs) begin curV = cfgSel[1:0]; curB = cfgSel[2]; end
    hit = 3'b000;
    if (vbi) begin
      if (effB) begin
        if (capQ.size() < CAP_D) capQ.push_back({1'b1, d}); else hit[0] = 1;
      end else begin
        if (tvQ.size() < TV_D) tvQ.push_back(d); else hit[2] = 1;
      end
    end else if (effV == 2'b00) begin
      if (dvQ.size() < DV_D) dvQ.push_back(d); else hit[1] = 1;
    end else if (effV == 2'b01) begin
      if (capQ.size() < CAP_D) capQ.push_back({1'b0, d}); else hit[0] = 1;
    end
    expOvf = (expOvf & ~clr) | hit;
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge inClk);
      inValid = 0; frameStart = 0; ovfClear = 0;
    end
  endtask

  task automatic pulseClear(logic [2:0] clr);
    @(negedge inClk);
    inValid = 0; frameStart = 0; ovfClear = clr;
    expOvf = expOvf & ~clr;
    idle(2);
  endtask

  task automatic drainCap(string tag);
    logic [8:0] e;
    forever begin
      @(negedge capClk);
      capRd = 0;
      if (capEmpty) break;
      if (capQ.size() == 0) chk({tag, " R6 extra capture entry"}, 1, 0);
      else begin
        e = capQ.pop_front();
        chk({tag, " R6 capture data"}, int'(capData), int'(e[7:0]));
        chk({tag, " R2/R3 capture tag"}, int'(capIsVbi), int'(e[8]));
      end
      capRd = 1;
    end
    // R10: reads on an empty buffer
    repeat (3) begin @(negedge capClk); capRd = 1; end
    @(negedge capClk); capRd = 0;
    chk({tag, " R6 capture count"}, capQ.size(), 0);
  endtask

  task automatic drainDv(string tag);
    logic [7:0] e;
    forever begin
      @(negedge dvClk);
      dvRd = 0;
      if (dvEmpty) break;
      if (dvQ.size() == 0) chk({tag, " R6 extra direct video entry"}, 1, 0);
      else begin
        e = dvQ.pop_front();
        chk({tag, " R6 direct video data"}, int'(dvData), int'(e));
      end
      dvRd = 1;
    end
    repeat (3) begin @(negedge dvClk); dvRd = 1; end  // R10
    @(negedge dvClk); dvRd = 0;
    chk({tag, " R6 direct video count"}, dvQ.size(), 0);
  endtask

  task automatic drainTv(string tag);
    logic [7:0] e;
    forever begin
      @(negedge tvClk);
      tvRd = 0;
      if (tvEmpty) break;
      if (tvQ.size() == 0) chk({tag, " R6 extra direct VBI entry"}, 1, 0);
      else begin
        e = tvQ.pop_front();
        chk({tag, " R6 direct VBI data"}, int'(tvData), int'(e));
      end
      tvRd = 1;
    end
    repeat (3) begin @(negedge tvClk); tvRd = 1; end  // R10
    @(negedge tvClk); tvRd = 0;
    chk({tag, " R6 direct VBI count"}, tvQ.size(), 0);
  endtask

  task automatic drainAll(string tag);
    idle(10);
    drainCap(tag);
    drainDv(tag);
    drainTv(tag);
    idle(10);
  endtask

  initial begin
    repeat (150000) @(posedge inClk);
    nChk++; nBad++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge inClk);
    rstN = 1;
    idle(2);
    // R1 reset state
    chk("R1 capEmpty", int'(capEmpty), 1);
    chk("R1 dvEmpty",  int'(dvEmpty), 1);
    chk("R1 tvEmpty",  int'(tvEmpty), 1);
    chk("R1 ovfFlag",  int'(ovfFlag), 0);

    // R1 default selects are direct: no strobe, cfgSel deliberately non-zero
    cfgSel = 3'b111;
    for (int i = 0; i < 12; i++) sendByte(8'(i * 7 + 3), (i % 2) == 1, 1'b0, 3'b000);
    drainAll("R1 default direct");

    // R2 R3 R4: sweep every select value; strobe rides with the first byte
    for (int ph = 0; ph < 8; ph++) begin
      cfgSel = 3'(ph);
      for (int i = 0; i < 24; i++)
        sendByte(8'(ph * 37 + i * 11), ((i + ph) % 3) == 0, i == 0, 3'b000);
      drainAll($sformatf("R4 sweep sel=%0d", ph));
      chk("R2 no flag from discard", int'(ovfFlag), int'(expOvf));
    end

    // R5: select change without strobe is ignored, then adopted on the strobe
    cfgSel = 3'b000;
    for (int i = 0; i < 10; i++) sendByte(8'(200 + i), (i % 2) == 0, i == 0, 3'b000);
    cfgSel = 3'b101;
    for (int i = 0; i < 10; i++) sendByte(8'(100 + i), (i % 2) == 1, 1'b0, 3'b000);
    for (int i = 0; i < 10; i++) sendByte(8'(50 + i), (i % 3) == 0, i == 0, 3'b000);
    drainAll("R5 strobe adoption");

    // R7 R8 R9 capture: fill, overflow, clear coinciding with a drop
    cfgSel = 3'b001;
    for (int i = 0; i < CAP_D + 2; i++) sendByte(8'(i * 3), 1'b0, i == 0, 3'b000);
    idle(2);
    chk("R8 capture overflow flag", int'(ovfFlag), 1);
    sendByte(8'hAA, 1'b0, 1'b0, 3'b001);
    idle(2);
    chk("R9 drop beats clear", int'(ovfFlag), int'(expOvf));
    chk("R9 drop beats clear (bit 0 set)", int'(ovfFlag[0]), 1);
    pulseClear(3'b001);
    chk("R9 clear", int'(ovfFlag), 0);
    drainAll("R7 R8 capture 128");

    // R7 R8 direct paths: 2048 video and 128 VBI, plus extras
    cfgSel = 3'b000;
    for (int i = 0; i < DV_D + 2; i++) sendByte(8'(i ^ (i >> 8)), 1'b0, i == 0, 3'b000);
    for (int i = 0; i < TV_D + 3; i++) sendByte(8'(i * 5 + 1), 1'b1, 1'b0, 3'b000);
    idle(2);
    chk("R8 direct overflow flags", int'(ovfFlag), 6);
    pulseClear(3'b010);
    chk("R9 clear direct video only", int'(ovfFlag), 4);
    pulseClear(3'b100);
    chk("R9 clear direct VBI", int'(ovfFlag), 0);
    drainAll("R7 R8 direct full");

    // R10: after empty reads, normal traffic still lines up
    cfgSel = 3'b101;
    for (int i = 0; i < 16; i++) sendByte(8'(i * 13), (i % 4) == 0, i == 0, 3'b000);
    drainAll("R10 after empty reads");
    chk("R8 flags quiet", int'(ovfFlag), int'(expOvf));

    summary();
    $finish;
  end
endmodule